// File: doc/BRIEF.md
# Three-Moduli Residue-to-Binary Converter

This block turns a residue-number-system value held as three residues back into an ordinary binary integer. The moduli are 2^n−1, 2^n and 2^n+1, with n set by a parameter. The residue for 2^n−1 is n bits wide, the residue for 2^n is n bits wide, and the residue for 2^n+1 is n+1 bits wide. The output is the unique 3n-bit integer X in the range [0, 2^n·(2^{2n}−1)) that has those three residues.

The residue modulo 2^n becomes the low n bits of X without change. The upper 2n-bit word is a sum of four operands taken modulo 2^{2n}−1. The operands come only from rotations, shifts and complements of the residues, so no multiplier is needed. Two carry-save rows with end-around carries reduce the four operands to two. Two parallel adders then form a+b and a+b+1. The carry-out of a+b+1 picks which of the two sums is the reduced result.

A parameter selects the output stage. The output is either combinational or held in a register with one cycle of latency.

Top module: `rnsrc_conv`

## Requirements
- R1: The low n bits of `x_o` equal the residue input `x2_i`.
- R2: For every `x1_i` in 0..2^n−2, `x_o` modulo 2^n−1 equals `x1_i`.
- R3: For every `x3_i` in 0..2^n, including 2^n itself (only bit n set), `x_o` modulo 2^n+1 equals `x3_i`.
- R4: `x_o` is always below 2^n·(2^{2n}−1). This means the upper 2n-bit word is never all ones: a reduced sum of 2^{2n}−1 is returned as zero.
- R5: For every valid residue triple, `x_o` is exactly the one integer X with X mod 2^n−1 = `x1_i`, X mod 2^n = `x2_i` and X mod 2^n+1 = `x3_i`. The extreme triples give X = 0 and X = 2^n·(2^{2n}−1)−1.
- R6: With `OUT_MODE` = registered, `x_o` shows the result for the inputs sampled at the previous rising `clk` edge. While `rst_n` is low, `x_o` is 0 whatever the inputs are, and it clears as soon as `rst_n` falls.
- R7: With `OUT_MODE` = combinational, `x_o` follows the inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x1_i | input | N | Residue modulo 2^N−1 |
| x2_i | input | N | Residue modulo 2^N |
| x3_i | input | N+1 | Residue modulo 2^N+1 |
| x_o | output | 3N | Reconstructed binary integer |

## Verification
The bench builds two copies of the block. One uses n = 4 with the registered output, and the other uses n = 3 with the combinational output. Each is small enough that every integer in the dynamic range (4080 and 504 values) can be applied as a residue triple and the exact result compared. That sweep reaches every valid triple, including residue 2^n+1 at its top value 2^n and the cases where the modulo 2^{2n}−1 sum lands on all ones. It also covers the register latency, reset held with live inputs, and an asynchronous reset in the middle of a run.

// File: rtl/rnsrc_pkg.sv
package rnsrc_pkg;

   // Output stage variant of the converter
   typedef enum logic {
      RNS_OUT_COMB = 1'b0,
      RNS_OUT_REG  = 1'b1
   } rns_out_mode_e;

endpackage

// File: rtl/rnsrc_opprep.sv
// Builds the four modulo (2^2N - 1) operands of the upper word by wiring only.
module rnsrc_opprep #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]   x1_i,
   input  logic [N-1:0]   x2_i,
   input  logic [N:0]     x3_i,
   output logic [2*N-1:0] op_a_o,
   output logic [2*N-1:0] op_b_o,
   output logic [2*N-1:0] op_c_o,
   output logic [2*N-1:0] op_d_o
);
   localparam int unsigned W = 2 * N;

   logic [W-1:0] x1_dup;
   logic [W-1:0] x3_ext;

   // (2^N + 1) * x1 is x1 duplicated; halving modulo 2^W - 1 is a rotate right
   assign x1_dup = {x1_i, x1_i};
   assign op_a_o = {x1_dup[0], x1_dup[W-1:1]};

   // -2^N * x2 : complemented residue above a field of ones
   assign op_b_o = {~x2_i, {N{1'b1}}};

   // x3 * 2^(N-1) : fits without wrap, including x3 = 2^N
   assign op_c_o = {x3_i, {(N-1){1'b0}}};

   // -x3 / 2 : rotate right by one, then one's complement
   assign x3_ext = {{(N-1){1'b0}}, x3_i};
   assign op_d_o = ~{x3_ext[0], x3_ext[W-1:1]};

endmodule

// File: rtl/rnsrc_csa_eac.sv
// One carry-save row whose top carry wraps around to bit 0 (modulo 2^W - 1).
module rnsrc_csa_eac #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cy_o
);
   logic [W-1:0] maj;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
      assign maj[i]   = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
   end

   assign cy_o = {maj[W-2:0], maj[W-1]};

endmodule

// File: rtl/rnsrc_eac_cpa.sv
// Final modulo (2^W - 1) addition: two parallel adders and a select.
module rnsrc_eac_cpa #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);
   logic [W:0] sum_plain;
   logic [W:0] sum_inc;

   assign sum_plain = {1'b0, a_i} + {1'b0, b_i};
   assign sum_inc   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, 1'b1};

   // a+b >= 2^W - 1 exactly when a+b+1 carries out; this also maps all-ones to 0
   assign y_o = sum_inc[W] ? sum_inc[W-1:0] : sum_plain[W-1:0];

endmodule

// File: rtl/rnsrc_conv.sv
module rnsrc_conv
   import rnsrc_pkg::*;
#(
   parameter int unsigned   N        = 4,
   parameter rns_out_mode_e OUT_MODE = RNS_OUT_REG
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   x1_i,
   input  logic [N-1:0]   x2_i,
   input  logic [N:0]     x3_i,
   output logic [3*N-1:0] x_o
);
   localparam int unsigned W  = 2 * N;
   localparam int unsigned XW = 3 * N;

   if (N < 2) begin : g_bad_n
      $error("rnsrc_conv: N must be at least 2");
   end

   logic [W-1:0]  op_a, op_b, op_c, op_d;
   logic [W-1:0]  s1, c1, s2, c2;
   logic [W-1:0]  upper;
   logic [XW-1:0] x_comb;

   rnsrc_opprep #(.N(N)) opprep_i (
      .x1_i   (x1_i),
      .x2_i   (x2_i),
      .x3_i   (x3_i),
      .op_a_o (op_a),
      .op_b_o (op_b),
      .op_c_o (op_c),
      .op_d_o (op_d)
   );

   rnsrc_csa_eac #(.W(W)) csa1_i (
      .a_i   (op_a),
      .b_i   (op_b),
      .c_i   (op_c),
      .sum_o (s1),
      .cy_o  (c1)
   );

   rnsrc_csa_eac #(.W(W)) csa2_i (
      .a_i   (s1),
      .b_i   (c1),
      .c_i   (op_d),
      .sum_o (s2),
      .cy_o  (c2)
   );

   rnsrc_eac_cpa #(.W(W)) cpa_i (
      .a_i (s2),
      .b_i (c2),
      .y_o (upper)
   );

   assign x_comb = {upper, x2_i};

   if (OUT_MODE == RNS_OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) x_o <= '0;
         else        x_o <= x_comb;
      end
   end else begin : g_out_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign x_o = x_comb;
   end

endmodule

// File: rtl/rnsrc_conv_chk.sv
module rnsrc_conv_chk
   import rnsrc_pkg::*;
#(
   parameter int unsigned   N        = 4,
   parameter rns_out_mode_e OUT_MODE = RNS_OUT_REG
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   x1_i,
   input logic [N-1:0]   x2_i,
   input logic [N:0]     x3_i,
   input logic [3*N-1:0] x_o
);
   localparam int unsigned XW = 3 * N;
   localparam logic [XW-1:0] ONE = XW'(1);
   localparam logic [XW-1:0] M1V = (ONE << N) - ONE;
   localparam logic [XW-1:0] M3V = (ONE << N) + ONE;
   localparam logic [XW-1:0] MV  = (ONE << N) * ((ONE << (2 * N)) - ONE);

   logic [N-1:0] x1_q, x2_q;
   logic [N:0]   x3_q;

   if (OUT_MODE == RNS_OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            x1_q <= '0;
            x2_q <= '0;
            x3_q <= '0;
         end else begin
            x1_q <= x1_i;
            x2_q <= x2_i;
            x3_q <= x3_i;
         end
      end
   end else begin : g_nodly
      assign x1_q = x1_i;
      assign x2_q = x2_i;
      assign x3_q = x3_i;
   end

   // R1
   low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      x_o[N-1:0] == x2_q);

   // R2
   mod_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_o % M1V) == (XW'(x1_q) % M1V));

   // R3
   mod_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (XW'(x3_q) <= (ONE << N)) |-> ((x_o % M3V) == XW'(x3_q)));

   // R4
   in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      x_o < MV);

endmodule

bind rnsrc_conv rnsrc_conv_chk #(.N(N), .OUT_MODE(OUT_MODE)) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .x1_i  (x1_i),
   .x2_i  (x2_i),
   .x3_i  (x3_i),
   .x_o   (x_o)
);

// File: tb/rnsrc_conv_tb_top.sv
module rnsrc_conv_tb_top;
   import rnsrc_pkg::*;

   localparam int NA  = 4;
   localparam int M1A = (1 << NA) - 1;
   localparam int M2A = 1 << NA;
   localparam int M3A = (1 << NA) + 1;
   localparam int MA  = M1A * M2A * M3A;
   localparam int NB  = 3;
   localparam int M1B = (1 << NB) - 1;
   localparam int M2B = 1 << NB;
   localparam int M3B = (1 << NB) + 1;
   localparam int MB  = M1B * M2B * M3B;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NA-1:0]   a_x1 = '0, a_x2 = '0;
   logic [NA:0]     a_x3 = '0;
   logic [3*NA-1:0] a_x;
   logic [NB-1:0]   b_x1 = '0, b_x2 = '0;
   logic [NB:0]     b_x3 = '0;
   logic [3*NB-1:0] b_x;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rnsrc_conv #(.N(NA), .OUT_MODE(RNS_OUT_REG)) dut_i (
      .clk(clk), .rst_n(rst_n), .x1_i(a_x1), .x2_i(a_x2), .x3_i(a_x3), .x_o(a_x));

   rnsrc_conv #(.N(NB), .OUT_MODE(RNS_OUT_COMB)) dut3_i (
      .clk(clk), .rst_n(rst_n), .x1_i(b_x1), .x2_i(b_x2), .x3_i(b_x3), .x_o(b_x));

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input int xa, input int xb);
      a_x1 = NA'(xa % M1A);
      a_x2 = NA'(xa % M2A);
      a_x3 = (NA+1)'(xa % M3A);
      b_x1 = NB'(xb % M1B);
      b_x2 = NB'(xb % M2B);
      b_x3 = (NB+1)'(xb % M3B);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog on R5 sweep actual running expected done");
      finish_run();
   end

   initial begin
      longint prev;
      repeat (3) @(negedge clk);
      check("R6 reset value", longint'(a_x), 0);
      // inputs live while reset is held
      drive(MA - 1, MB - 1);
      @(negedge clk);
      @(negedge clk);
      check("R6 reset holds with live inputs", longint'(a_x), 0);
      rst_n = 1'b1;
      prev = MA - 1;
      for (int x = 0; x < MA; x++) begin
         @(negedge clk);
         drive(x, x % MB);
         #1;
         // R7: combinational copy answers before any edge
         check("R7 R5 same-cycle exact value", longint'(b_x), longint'(x % MB));
         // R6: registered copy still shows previous result
         check("R6 one-cycle latency", longint'(a_x), prev);
         @(posedge clk);
         #1;
         check("R1 low bits", longint'(a_x) % M2A, longint'(x % M2A));
         check("R2 mod 2^n-1", longint'(a_x) % M1A, longint'(x % M1A));
         check("R3 mod 2^n+1", longint'(a_x) % M3A, longint'(x % M3A));
         check("R4 below range", longint'(longint'(a_x) < MA), 1);
         check("R5 exact value", longint'(a_x), longint'(x));
         prev = x;
      end
      // R3 top residue 2^n, R5 extremes
      @(negedge clk);
      drive(MA - 1, 0);
      @(posedge clk);
      #1;
      check("R3 R5 top of range", longint'(a_x), longint'(MA - 1));
      check("R5 zero triple comb", longint'(b_x), 0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R6 async clear", longint'(a_x), 0);
      finish_run();
   end

endmodule